// File: doc/BRIEF.md
# Configurable Product-Term Array

This block is the programmable AND plane of a small registered sequencer. Sixteen input variables feed every term: four dedicated inputs, four lines from bidirectional pins, and eight register feedbacks. There are 45 product terms, 32 logic terms and 13 control terms. Each term decides per variable whether it takes the true form, the complement form, neither, or both. Taking both forms makes the term constant zero. A shared complement signal is the NOR over a chosen set of terms, and other terms can take it as one more AND input. This gives a cheap way to build the "none of these" condition of a state machine.

Each term's links are held in a configuration register that is loaded serially, one bit per clock. Term outputs are purely combinational from the present configuration and inputs. An unloaded array has every link intact, so every term reads zero. A configuration in which a term both drives and consumes the complement signal would oscillate in a fused array. The block raises a flag for it.

Top module: `pterm_array`

## Requirements
- R1: A synchronous reset (rstN low at a rising clock edge) sets every configuration bit to 1 (link intact), taking priority over loading. With that configuration all 45 term outputs are 0, compOut is 1 and illegalCfg is 0.
- R2: On each rising edge with rstN high and cfgLoad high, the configuration word shifts one place toward its top bit and cfgBit enters bit 0. With cfgLoad low the word, and so every output, is unchanged whatever cfgBit does.
- R3: Term t occupies configuration bits [34t+33 : 34t]. Within a term, the pair for variable v sits at bits 2v+1 (true link) and 2v (complement link). Variables 0-3 are dedIn[3:0], 4-7 are bidirIn[3:0] and 8-15 are fbIn[7:0]. Bit 33 is the generate link and bit 32 the propagate link.
- R4: A term whose pair for any variable reads 11 (both links intact) outputs 0 for every input pattern.
- R5: Pair code 10 requires the variable to be 1, code 01 requires it to be 0, and code 00 makes the variable a don't care. The term's base value is the AND of all its variable conditions.
- R6: compOut is the NOR of the base values of all terms whose generate link (bit 33) is 1. It is 1 when no such term is true.
- R7: A term whose propagate link (bit 32) is 1 outputs its base value ANDed with compOut. A term whose propagate link is 0 outputs its base value alone.
- R8: illegalCfg is 1 exactly when some term has both bit 33 and bit 32 set and has no variable pair reading 11. The generating contribution of such a term uses its base value.
- R9: Terms 0-31 appear on logicTerm[31:0], and terms 32-44 appear on ctrlTerm[12:0] (term 32+k on bit k).
- R10: Outputs follow input changes combinationally, with no clock edge needed.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rstN | input | 1 | Synchronous active-low reset to the all-intact configuration |
| cfgLoad | input | 1 | Shift enable for serial configuration |
| cfgBit | input | 1 | Serial configuration data |
| dedIn | input | 4 | Dedicated inputs, variables 0-3 |
| bidirIn | input | 4 | Bidirectional line values, variables 4-7 |
| fbIn | input | 8 | Register feedback values, variables 8-15 |
| logicTerm | output | 32 | Logic term outputs 0-31 |
| ctrlTerm | output | 13 | Control term outputs 32-44 |
| compOut | output | 1 | Complement signal |
| illegalCfg | output | 1 | A term both generates and consumes the complement signal |

## Verification
The bench aims at terms pinned to zero by a both-intact pair. A design that lets such a term through would show stray ones when the other conditions match. It also aims at a lone generator term whose condition toggles. A design with an inverted or missing NOR would leave propagating terms stuck or never gated. Self-feeding terms are loaded both with and without a forcing pair, so a design that flags forced-off terms, or that misses live ones, disagrees on illegalCfg. The last logic term and the first control term are each given a unique condition, so any misplaced field or split point shows up. Partial loads and idle clocks with cfgBit toggling catch a shift that runs in the wrong direction or fails to hold.

// File: rtl/pterm_pkg.sv
package pterm_pkg;

  localparam int DEF_DED   = 4;
  localparam int DEF_BIDIR = 4;
  localparam int DEF_FB    = 8;
  localparam int DEF_LOGIC = 32;
  localparam int DEF_CTRL  = 13;

  localparam int DEF_VARS      = DEF_DED + DEF_BIDIR + DEF_FB;
  localparam int DEF_TERMS     = DEF_LOGIC + DEF_CTRL;
  localparam int DEF_TERM_BITS = 2 * DEF_VARS + 2;
  localparam int DEF_CFG_BITS  = DEF_TERMS * DEF_TERM_BITS;

  // Strobes from the control side to the configuration store
  typedef struct packed {
    logic clearAll;
    logic shiftEn;
    logic shiftBit;
  } cfgStrobe_t;

endpackage

// File: rtl/pterm_ctrl.sv
module pterm_ctrl
  import pterm_pkg::*;
(
  input  logic       rstN,
  input  logic       cfgLoad,
  input  logic       cfgBit,
  output cfgStrobe_t stb
);

  // Reset wins over loading; data rides along with the shift strobe
  always_comb begin
    stb.clearAll = ~rstN;
    stb.shiftEn  = rstN & cfgLoad;
    stb.shiftBit = cfgBit;
  end

endmodule

// File: rtl/pterm_cfg_store.sv
module pterm_cfg_store
  import pterm_pkg::*;
#(
  parameter int CFG_BITS = DEF_CFG_BITS
) (
  input  logic                clk,
  input  cfgStrobe_t          stb,
  output logic [CFG_BITS-1:0] cfgWord
);

  always_ff @(posedge clk) begin
    if (stb.clearAll) begin
      cfgWord <= '1;
    end else if (stb.shiftEn) begin
      cfgWord <= {cfgWord[CFG_BITS-2:0], stb.shiftBit};
    end
  end

endmodule

// File: rtl/pterm_eval.sv
module pterm_eval #(
  parameter int NUM_VARS  = 16,
  parameter int NUM_TERMS = 45,
  parameter int TERM_BITS = 2 * NUM_VARS + 2
) (
  input  logic [NUM_TERMS*TERM_BITS-1:0] cfgWord,
  input  logic [NUM_VARS-1:0]            varIn,
  output logic [NUM_TERMS-1:0]           termVal,
  output logic                           compOut,
  output logic                           illegalCfg
);

  localparam int CSEL = 2 * NUM_VARS;

  logic [NUM_TERMS-1:0] baseVal;
  logic [NUM_TERMS-1:0] forcedOff;
  logic [NUM_TERMS-1:0] genOn;
  logic [NUM_TERMS-1:0] propOn;

  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    logic [TERM_BITS-1:0] tc;
    logic [NUM_VARS-1:0]  hit;
    logic [NUM_VARS-1:0]  both;

    assign tc = cfgWord[t*TERM_BITS +: TERM_BITS];

    for (genvar v = 0; v < NUM_VARS; v++) begin : g_var
      // An intact link passes its literal; a blown link reads as 1
      assign hit[v]  = (~tc[2*v+1] | varIn[v]) & (~tc[2*v] | ~varIn[v]);
      assign both[v] = tc[2*v+1] & tc[2*v];
    end

    assign baseVal[t]   = &hit;
    assign forcedOff[t] = |both;
    assign genOn[t]     = tc[CSEL+1];
    assign propOn[t]    = tc[CSEL];
  end

  // Generators contribute their base value, which keeps the path loop-free
  assign compOut    = ~|(baseVal & genOn);
  assign termVal    = baseVal & (~propOn | {NUM_TERMS{compOut}});
  assign illegalCfg = |(genOn & propOn & ~forcedOff);

endmodule

// File: rtl/pterm_array.sv
module pterm_array
  import pterm_pkg::*;
#(
  parameter int NUM_DED   = DEF_DED,
  parameter int NUM_BIDIR = DEF_BIDIR,
  parameter int NUM_FB    = DEF_FB,
  parameter int NUM_LOGIC = DEF_LOGIC,
  parameter int NUM_CTRL  = DEF_CTRL
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgLoad,
  input  logic                 cfgBit,
  input  logic [NUM_DED-1:0]   dedIn,
  input  logic [NUM_BIDIR-1:0] bidirIn,
  input  logic [NUM_FB-1:0]    fbIn,
  output logic [NUM_LOGIC-1:0] logicTerm,
  output logic [NUM_CTRL-1:0]  ctrlTerm,
  output logic                 compOut,
  output logic                 illegalCfg
);

  localparam int NUM_VARS  = NUM_DED + NUM_BIDIR + NUM_FB;
  localparam int NUM_TERMS = NUM_LOGIC + NUM_CTRL;
  localparam int TERM_BITS = 2 * NUM_VARS + 2;
  localparam int CFG_BITS  = NUM_TERMS * TERM_BITS;

  cfgStrobe_t           stb;
  logic [CFG_BITS-1:0]  cfgWord;
  logic [NUM_VARS-1:0]  varIn;
  logic [NUM_TERMS-1:0] termVal;

  assign varIn = {fbIn, bidirIn, dedIn};

  pterm_ctrl u_ctrl (
    .rstN    (rstN),
    .cfgLoad (cfgLoad),
    .cfgBit  (cfgBit),
    .stb     (stb)
  );

  pterm_cfg_store #(.CFG_BITS(CFG_BITS)) u_store (
    .clk     (clk),
    .stb     (stb),
    .cfgWord (cfgWord)
  );

  pterm_eval #(
    .NUM_VARS  (NUM_VARS),
    .NUM_TERMS (NUM_TERMS),
    .TERM_BITS (TERM_BITS)
  ) u_eval (
    .cfgWord    (cfgWord),
    .varIn      (varIn),
    .termVal    (termVal),
    .compOut    (compOut),
    .illegalCfg (illegalCfg)
  );

  assign logicTerm = termVal[NUM_LOGIC-1:0];
  assign ctrlTerm  = termVal[NUM_TERMS-1:NUM_LOGIC];

endmodule

// File: rtl/pterm_array_chk.sv
module pterm_array_chk
  import pterm_pkg::*;
(
  input logic                    clk,
  input logic                    rstN,
  input logic                    cfgLoad,
  input logic                    cfgBit,
  input logic [DEF_CFG_BITS-1:0] cfgWord,
  input logic [DEF_LOGIC-1:0]    logicTerm,
  input logic [DEF_CTRL-1:0]     ctrlTerm,
  input logic                    compOut,
  input logic                    illegalCfg
);

  logic [DEF_TERMS-1:0] allTerms;
  logic [DEF_TERMS-1:0] forcedMask;
  logic [DEF_TERMS-1:0] genMask;
  logic [DEF_TERMS-1:0] propMask;

  assign allTerms = {ctrlTerm, logicTerm};

  always_comb begin
    for (int t = 0; t < DEF_TERMS; t++) begin
      forcedMask[t] = 1'b0;
      for (int v = 0; v < DEF_VARS; v++) begin
        if (cfgWord[t*DEF_TERM_BITS + 2*v] && cfgWord[t*DEF_TERM_BITS + 2*v + 1])
          forcedMask[t] = 1'b1;
      end
      genMask[t]  = cfgWord[t*DEF_TERM_BITS + 2*DEF_VARS + 1];
      propMask[t] = cfgWord[t*DEF_TERM_BITS + 2*DEF_VARS];
    end
  end

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cfgLoad |=> $stable(cfgWord));

  assert_cfg_shift_R2: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> cfgWord == {$past(cfgWord[DEF_CFG_BITS-2:0]), $past(cfgBit)});

  assert_forced_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (allTerms & forcedMask) == '0);

  assert_no_gen_R6: assert property (@(posedge clk) disable iff (!rstN)
    (genMask == '0) |-> compOut);

  assert_prop_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    !compOut |-> ((allTerms & propMask) == '0));

  assert_all_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    (&forcedMask) |-> !illegalCfg);

endmodule

bind pterm_array pterm_array_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgLoad    (cfgLoad),
  .cfgBit     (cfgBit),
  .cfgWord    (cfgWord),
  .logicTerm  (logicTerm),
  .ctrlTerm   (ctrlTerm),
  .compOut    (compOut),
  .illegalCfg (illegalCfg)
);

// File: tb/pterm_array_tb.sv
module pterm_array_tb;
  import pterm_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NV = DEF_VARS;
  localparam int NT = DEF_TERMS;
  localparam int TB = DEF_TERM_BITS;
  localparam int CB = DEF_CFG_BITS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 1'b0;
  logic cfgBit = 1'b0;
  logic [3:0] dedIn = '0;
  logic [3:0] bidirIn = '0;
  logic [7:0] fbIn = '0;
  logic [31:0] logicTerm;
  logic [12:0] ctrlTerm;
  logic compOut;
  logic illegalCfg;

  logic [CB-1:0] mdl = '1;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pterm_array u_dut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgBit(cfgBit),
    .dedIn(dedIn), .bidirIn(bidirIn), .fbIn(fbIn),
    .logicTerm(logicTerm), .ctrlTerm(ctrlTerm),
    .compOut(compOut), .illegalCfg(illegalCfg)
  );

  // Reference model written from the requirements
  function automatic void refEval(input logic [CB-1:0] cfg, input logic [NV-1:0] x,
                                  output logic [NT-1:0] tv, output logic c, output logic ill);
    logic [NT-1:0] base, forced, gen, prop;
    for (int t = 0; t < NT; t++) begin
      base[t] = 1'b1;
      forced[t] = 1'b0;
      for (int v = 0; v < NV; v++) begin
        logic tl, cl;
        tl = cfg[t*TB + 2*v + 1];
        cl = cfg[t*TB + 2*v];
        if (tl && cl) forced[t] = 1'b1;
        else if (tl && !x[v]) base[t] = 1'b0;
        else if (cl && x[v]) base[t] = 1'b0;
      end
      if (forced[t]) base[t] = 1'b0;
      gen[t]  = cfg[t*TB + 2*NV + 1];
      prop[t] = cfg[t*TB + 2*NV];
    end
    c = 1'b1;
    ill = 1'b0;
    for (int t = 0; t < NT; t++) begin
      if (gen[t] && base[t]) c = 1'b0;
      if (gen[t] && prop[t] && !forced[t]) ill = 1'b1;
    end
    for (int t = 0; t < NT; t++) tv[t] = base[t] && (!prop[t] || c);
  endfunction

  function automatic logic [CB-1:0] setPair(input logic [CB-1:0] cfg, input int t,
                                            input int v, input logic [1:0] code);
    logic [CB-1:0] r = cfg;
    r[t*TB + 2*v +: 2] = code;
    return r;
  endfunction

  function automatic logic [CB-1:0] setComp(input logic [CB-1:0] cfg, input int t,
                                            input logic [1:0] code);
    logic [CB-1:0] r = cfg;
    r[t*TB + 2*NV +: 2] = code;
    return r;
  endfunction

  // Make term t fully don't-care with a given complement code
  function automatic logic [CB-1:0] openTerm(input logic [CB-1:0] cfg, input int t,
                                             input logic [1:0] ccode);
    logic [CB-1:0] r = cfg;
    for (int v = 0; v < NV; v++) r[t*TB + 2*v +: 2] = 2'b00;
    r[t*TB + 2*NV +: 2] = ccode;
    return r;
  endfunction

  function automatic logic [CB-1:0] randCfg();
    logic [CB-1:0] r;
    for (int t = 0; t < NT; t++) begin
      for (int v = 0; v < NV; v++) begin
        int k;
        k = int'($urandom % 32);
        if (k < 28) r[t*TB + 2*v +: 2] = 2'b00;
        else if (k < 30) r[t*TB + 2*v +: 2] = 2'b10;
        else if (k < 31) r[t*TB + 2*v +: 2] = 2'b01;
        else r[t*TB + 2*v +: 2] = 2'b11;
      end
      r[t*TB + 2*NV +: 2] = 2'($urandom % 4);
    end
    return r;
  endfunction

  task automatic checkOut(input string req);
    logic [NT-1:0] tv;
    logic c, ill;
    refEval(mdl, {fbIn, bidirIn, dedIn}, tv, c, ill);
    checks += 4;
    if (logicTerm !== tv[31:0]) begin
      errors++;
      $display("FAIL %s logicTerm actual %h expected %h", req, logicTerm, tv[31:0]);
    end
    if (ctrlTerm !== tv[NT-1:32]) begin
      errors++;
      $display("FAIL %s ctrlTerm actual %h expected %h", req, ctrlTerm, tv[NT-1:32]);
    end
    if (compOut !== c) begin
      errors++;
      $display("FAIL %s compOut actual %b expected %b", req, compOut, c);
    end
    if (illegalCfg !== ill) begin
      errors++;
      $display("FAIL %s illegalCfg actual %b expected %b", req, illegalCfg, ill);
    end
  endtask

  task automatic checkResetState();
    checks++;
    if (logicTerm !== '0 || ctrlTerm !== '0 || compOut !== 1'b1 || illegalCfg !== 1'b0) begin
      errors++;
      $display("FAIL R1 outputs actual %h/%h/%b/%b expected 0/0/1/0",
               logicTerm, ctrlTerm, compOut, illegalCfg);
    end
  endtask

  task automatic setIn(input logic [3:0] d, input logic [3:0] b, input logic [7:0] f);
    dedIn = d;
    bidirIn = b;
    fbIn = f;
    #1;
  endtask

  task automatic shiftIn(input logic b);
    @(negedge clk);
    cfgLoad = 1'b1;
    cfgBit = b;
    @(posedge clk);
    mdl = {mdl[CB-2:0], b};
  endtask

  task automatic loadCfg(input logic [CB-1:0] cfg);
    for (int i = CB - 1; i >= 0; i--) shiftIn(cfg[i]);
    @(negedge clk);
    cfgLoad = 1'b0;
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    mdl = '1;
    @(negedge clk);
    rstN = 1'b1;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [CB-1:0] cfg;
    void'($urandom(32'h5eed_0c41));

    // R1: reset configuration
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    checkResetState();
    setIn(4'hf, 4'ha, 8'h5c);
    checkResetState();

    // R3 R5: single term with a true and a complement condition
    cfg = '1;
    cfg = openTerm(cfg, 7, 2'b00);
    cfg = setPair(cfg, 7, 2, 2'b10);
    cfg = setPair(cfg, 7, 9, 2'b01);
    loadCfg(cfg);
    for (int p = 0; p < 4; p++) begin
      setIn({1'b0, p[1], 2'b01}, 4'h3, {6'h2a, p[0], 1'b1});
      checkOut("R5");
      checkOut("R3");
    end

    // R9: boundary between logic and control outputs
    cfg = '1;
    cfg = openTerm(cfg, 31, 2'b00);
    cfg = setPair(cfg, 31, 7, 2'b10);
    cfg = openTerm(cfg, 32, 2'b00);
    cfg = setPair(cfg, 32, 15, 2'b01);
    cfg = openTerm(cfg, 44, 2'b00);
    cfg = setPair(cfg, 44, 0, 2'b10);
    loadCfg(cfg);
    setIn(4'h1, 4'h8, 8'h00); checkOut("R9");
    setIn(4'h0, 4'h0, 8'h80); checkOut("R9");
    setIn(4'h1, 4'h0, 8'h00); checkOut("R9");

    // R4: a both-intact pair beats otherwise matching conditions
    cfg = setPair(cfg, 31, 3, 2'b11);
    loadCfg(cfg);
    setIn(4'hf, 4'h8, 8'h00); checkOut("R4");
    setIn(4'h0, 4'h8, 8'h00); checkOut("R4");

    // R6 R7: generator, propagating and transparent terms
    cfg = '1;
    cfg = openTerm(cfg, 3, 2'b10);
    cfg = setPair(cfg, 3, 0, 2'b10);
    cfg = openTerm(cfg, 4, 2'b01);
    cfg = openTerm(cfg, 5, 2'b00);
    cfg = openTerm(cfg, 40, 2'b01);
    loadCfg(cfg);
    setIn(4'h1, 4'h0, 8'h00); checkOut("R6"); checkOut("R7");
    setIn(4'h0, 4'h0, 8'h00); checkOut("R6"); checkOut("R7");
    setIn(4'h1, 4'h0, 8'h00); checkOut("R10");

    // R8: self-feeding term live, then forced off
    cfg = openTerm(cfg, 6, 2'b11);
    loadCfg(cfg);
    setIn(4'h0, 4'h0, 8'h00); checkOut("R8");
    cfg = setPair(cfg, 6, 12, 2'b11);
    loadCfg(cfg);
    checkOut("R8");

    // R2: idle clocks with cfgBit toggling leave everything alone
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      cfgLoad = 1'b0;
      cfgBit = i[0];
      @(posedge clk);
    end
    @(negedge clk);
    #1;
    checkOut("R2");

    // Random configurations and input vectors
    for (int n = 0; n < 16; n++) begin
      loadCfg(randCfg());
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        setIn(4'($urandom), 4'($urandom), 8'($urandom));
        checkOut("R5");
      end
    end

    // R2: partial load leaves a shifted mix of old and new bits
    cfg = randCfg();
    for (int i = CB - 1; i >= CB - 700; i--) shiftIn(cfg[i]);
    @(negedge clk);
    cfgLoad = 1'b0;
    #1;
    checkOut("R2");

    // R1: reset clears a loaded configuration, also with load held high
    cfgLoad = 1'b1;
    doReset();
    cfgLoad = 1'b0;
    #1;
    checkResetState();
    checkOut("R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule